// File: doc/BRIEF.md
# Fixed-Block Prefetch Hint Unit

This unit sits beside an instruction stream and picks out two prefetch hints hidden inside logical-immediate encodings. An OR-immediate or AND-immediate whose destination is register zero has no architectural effect as an ALU operation, so it is read as a prefetch of the 64-byte block around `base + offset`. The OR form asks for read access and the AND form asks for write intent. The unit forms the effective address and fits the 64-byte block onto the configured cache line size. It then emits one or two line requests on a valid/ready port.

Each hint is filtered before any request leaves. A page fault reported by the translation port drops the hint silently. A hit on an armed data breakpoint raises a debug exception instead, and no request is issued. Every other instruction is accepted and produces nothing. The caller offers one instruction per handshake together with the value of its base register. The unit takes it when `in_ready` is high.

Back-pressure rules: `req_valid`, once raised, stays high with `req_addr` and `req_write` unchanged until `req_ready` is seen high at a clock edge. `in_ready` is high when no line request is pending, or when exactly one is pending and `req_ready` is high in the same cycle. The unit therefore stalls its input while the second half of a split block is still waiting.

Top module: `blkpf_hint_unit`

## Requirements
- R1: A word with opcode bits [6:0] = 0010011, funct3 bits [14:12] = 110 and rd bits [11:7] = 0 is a read prefetch hint, and its requests carry `req_write` = 0.
- R2: The same opcode with funct3 = 111 and rd = 0 is a write-intent hint, and its requests carry `req_write` = 1.
- R3: The effective address is the base value plus bits [31:20] sign-extended from bit 31. It is shown on `xl_vaddr` while the instruction is offered.
- R4: With a 32-byte line, a hint emits exactly two requests, in this order: the effective address with its low 6 bits cleared, then that address plus 32.
- R5: With a line of 64 bytes or more, a hint emits exactly one request: the effective address with its low log2(line size) bits cleared.
- R6: If `xl_fault` is high when a hint is accepted, no request and no exception follow.
- R7: If `bkpt_armed` is high and bits [XLEN-1:6] of the effective address equal those of `bkpt_addr` when a hint is accepted, `dbg_exc` is high for exactly the next cycle with `dbg_exc_addr` equal to the effective address, and no request follows. This holds even when `xl_fault` is also high.
- R8: Any word that is not a hint, including the hint opcodes with rd not 0, is accepted with no request and no exception.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_write` hold, and `in_ready` is low.
- R10: The first request of an accepted hint is valid in the cycle after acceptance, and each further line is valid in the cycle after the previous handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take the instruction |
| in_insn | input | 32 | Instruction word |
| in_base | input | XLEN | Value of the base register |
| xl_vaddr | output | XLEN | Effective address presented for translation |
| xl_fault | input | 1 | Translation reports a page fault for `xl_vaddr` |
| bkpt_armed | input | 1 | Data breakpoint enabled |
| bkpt_addr | input | XLEN | Data breakpoint address |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Cache accepts the line request |
| req_addr | output | XLEN | Line-aligned request address |
| req_write | output | 1 | Request has write intent |
| dbg_exc | output | 1 | Debug exception pulse |
| dbg_exc_addr | output | XLEN | Effective address that hit the breakpoint |

## Verification
The bench sweeps every funct3 value, several destination registers and two opcodes against signed offsets and bases that sit near block edges. A decoder that missed the rd or opcode check would issue requests for ordinary ALU work, and an unsigned offset would land negative offsets in the wrong block. Split blocks are checked under held-off `req_ready`. A sequencer that advanced early would skip the +32 line or change the address while it is stalled. Fault and breakpoint are crossed, including the armed-but-other-block case. Getting the priority wrong would either lose the trap or leak a request past a fault.

// File: rtl/blkpf_pkg.sv
package blkpf_pkg;
  localparam int unsigned BLOCK_BYTES = 64;
  localparam int unsigned BLOCK_LG    = 6;
  localparam logic [6:0]  OPC_OPIMM   = 7'b0010011;
  localparam logic [2:0]  F3_ORI      = 3'b110;
  localparam logic [2:0]  F3_ANDI     = 3'b111;

  typedef struct packed {
    logic [6:0] opcode;
    logic [4:0] rd;
    logic [2:0] funct3;
    logic [4:0] rs1;
    logic [11:0] imm;
  } insn_fields_t;

  function automatic insn_fields_t split_insn(input logic [31:0] w);
    insn_fields_t f;
    f.opcode = w[6:0];
    f.rd     = w[11:7];
    f.funct3 = w[14:12];
    f.rs1    = w[19:15];
    f.imm    = w[31:20];
    return f;
  endfunction
endpackage

// File: rtl/blkpf_decode.sv
module blkpf_decode
  import blkpf_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] base,
  output logic            is_hint,
  output logic            is_write,
  output logic [XLEN-1:0] eff_addr
);
  insn_fields_t f;
  logic         rd_zero;
  logic         opc_ok;
  logic [XLEN-1:0] offset;

  always_comb begin
    f        = split_insn(insn);
    rd_zero  = (f.rd == 5'd0);
    opc_ok   = (f.opcode == OPC_OPIMM);
    is_hint  = opc_ok && rd_zero && ((f.funct3 == F3_ORI) || (f.funct3 == F3_ANDI));
    is_write = (f.funct3 == F3_ANDI);
    offset   = {{(XLEN-12){f.imm[11]}}, f.imm};
    eff_addr = base + offset;
  end
endmodule

// File: rtl/blkpf_split.sv
module blkpf_split
  import blkpf_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] first_line,
  output logic [1:0]      line_cnt
);
  localparam int unsigned LINE_LG = $clog2(LINE_BYTES);

  generate
    if (LINE_BYTES < BLOCK_BYTES) begin : g_split
      localparam int unsigned PIECES = BLOCK_BYTES / LINE_BYTES;
      always_comb begin
        first_line = {eff_addr[XLEN-1:BLOCK_LG], {BLOCK_LG{1'b0}}};
        line_cnt   = 2'(PIECES);
      end
    end else begin : g_whole
      always_comb begin
        first_line = {eff_addr[XLEN-1:LINE_LG], {LINE_LG{1'b0}}};
        line_cnt   = 2'd1;
      end
    end
  endgenerate
endmodule

// File: rtl/blkpf_reqseq.sv
module blkpf_reqseq #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] load_addr,
  input  logic [1:0]      load_cnt,
  input  logic            load_write,
  output logic            can_accept,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [XLEN-1:0] req_addr,
  output logic            req_write
);
  localparam int unsigned LINE_LG = $clog2(LINE_BYTES);

  logic [1:0]      left_q;
  logic [XLEN-1:0] addr_q;
  logic            wr_q;
  logic            fire;

  assign req_valid  = (left_q != 2'd0);
  assign req_addr   = addr_q;
  assign req_write  = wr_q;
  assign fire       = req_valid && req_ready;
  assign can_accept = (left_q == 2'd0) || ((left_q == 2'd1) && req_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= 2'd0;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (load) begin
      left_q <= load_cnt;
      addr_q <= load_addr;
      wr_q   <= load_write;
    end else if (fire) begin
      left_q <= left_q - 2'd1;
      if (left_q != 2'd1) addr_q <= addr_q + XLEN'(LINE_BYTES);
    end
  end

  // R9: a stalled request holds its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

  // R5: every emitted address is line aligned
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[LINE_LG-1:0] == '0));

  // R4: the second line of a split block follows the first by one line
  p_next_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && left_q == 2'd2) |=> (req_valid && req_addr == $past(req_addr) + XLEN'(LINE_BYTES)));
endmodule

// File: rtl/blkpf_hint_unit.sv
module blkpf_hint_unit
  import blkpf_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_base,
  output logic [XLEN-1:0] xl_vaddr,
  input  logic            xl_fault,
  input  logic            bkpt_armed,
  input  logic [XLEN-1:0] bkpt_addr,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [XLEN-1:0] req_addr,
  output logic            req_write,
  output logic            dbg_exc,
  output logic [XLEN-1:0] dbg_exc_addr
);
  logic            is_hint;
  logic            is_write;
  logic [XLEN-1:0] eff_addr;
  logic [XLEN-1:0] first_line;
  logic [1:0]      line_cnt;
  logic            accept;
  logic            bkpt_hit;
  logic            issue;
  logic            exc_q;
  logic [XLEN-1:0] exc_addr_q;

  blkpf_decode #(.XLEN(XLEN)) u_dec (
    .insn     (in_insn),
    .base     (in_base),
    .is_hint  (is_hint),
    .is_write (is_write),
    .eff_addr (eff_addr)
  );

  blkpf_split #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_split (
    .eff_addr   (eff_addr),
    .first_line (first_line),
    .line_cnt   (line_cnt)
  );

  assign xl_vaddr = eff_addr;
  assign accept   = in_valid && in_ready;
  assign bkpt_hit = bkpt_armed && (eff_addr[XLEN-1:BLOCK_LG] == bkpt_addr[XLEN-1:BLOCK_LG]);
  assign issue    = accept && is_hint && !bkpt_hit && !xl_fault;

  blkpf_reqseq #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (issue),
    .load_addr  (first_line),
    .load_cnt   (line_cnt),
    .load_write (is_write),
    .can_accept (in_ready),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q      <= 1'b0;
      exc_addr_q <= '0;
    end else begin
      exc_q <= accept && is_hint && bkpt_hit;
      if (accept && is_hint && bkpt_hit) exc_addr_q <= eff_addr;
    end
  end

  assign dbg_exc      = exc_q;
  assign dbg_exc_addr = exc_addr_q;

  // R8: non-hint words never raise the debug exception
  p_nonhint_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_hint) |=> !dbg_exc);

  // R10: a clean hint makes a request visible in the next cycle
  p_first_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_hint && !bkpt_hit && !xl_fault) |=> req_valid);

  // R6: a faulting hint that misses the breakpoint stays silent
  p_fault_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_hint && xl_fault && !bkpt_hit && !req_valid) |=> (!req_valid && !dbg_exc));

  // R7: the exception pulse lasts one cycle
  p_exc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc && !$past(accept)) |-> 1'b0);
endmodule

// File: tb/tb_blkpf_hint_unit.sv
module tb_blkpf_hint_unit;
  localparam int unsigned XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0]     in_insn = '0;
  logic [XLEN-1:0] in_base = '0;
  logic            xl_fault = 1'b0;
  logic            bkpt_armed = 1'b0;
  logic [XLEN-1:0] bkpt_addr = '0;

  logic            in_valid = 1'b0, in_ready;
  logic [XLEN-1:0] xl_vaddr;
  logic            req_valid, req_write, dbg_exc;
  logic            req_ready = 1'b0;
  logic [XLEN-1:0] req_addr, dbg_exc_addr;

  logic            w_in_valid = 1'b0, w_in_ready;
  logic [XLEN-1:0] w_vaddr, w_req_addr, w_exc_addr;
  logic            w_req_valid, w_req_write, w_exc;
  logic            w_req_ready = 1'b1;

  blkpf_hint_unit #(.XLEN(XLEN), .LINE_BYTES(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_base(in_base), .xl_vaddr(xl_vaddr), .xl_fault(xl_fault),
    .bkpt_armed(bkpt_armed), .bkpt_addr(bkpt_addr), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .dbg_exc(dbg_exc), .dbg_exc_addr(dbg_exc_addr));

  blkpf_hint_unit #(.XLEN(XLEN), .LINE_BYTES(256)) dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_in_valid), .in_ready(w_in_ready),
    .in_insn(in_insn), .in_base(in_base), .xl_vaddr(w_vaddr), .xl_fault(xl_fault),
    .bkpt_armed(bkpt_armed), .bkpt_addr(bkpt_addr), .req_valid(w_req_valid),
    .req_ready(w_req_ready), .req_addr(w_req_addr), .req_write(w_req_write),
    .dbg_exc(w_exc), .dbg_exc_addr(w_exc_addr));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [11:0] imm, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {imm, 5'd3, f3, rd, opc};
  endfunction

  function automatic logic [31:0] ea_of(input logic [31:0] insn, input logic [31:0] base);
    return base + {{20{insn[31]}}, insn[31:20]};
  endfunction

  function automatic bit hint_of(input logic [31:0] insn);
    return insn[6:0] == 7'b0010011 && insn[11:7] == 5'd0 &&
           (insn[14:12] == 3'b110 || insn[14:12] == 3'b111);
  endfunction

  task automatic run(input logic [31:0] insn, input logic [31:0] base, input bit flt,
                     input bit arm, input logic [31:0] baddr, input int delay, input string tag);
    logic [31:0] ea, blk;
    bit hint, exc;
    int nexp, n;
    logic [31:0] got [0:3];
    logic got_w [0:3];
    logic [31:0] held;
    bit seen;
    ea   = ea_of(insn, base);
    blk  = {ea[31:6], 6'd0};
    hint = hint_of(insn);
    exc  = hint && arm && (ea[31:6] == baddr[31:6]);
    nexp = (hint && !exc && !flt) ? 2 : 0;
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_base = base;
    xl_fault = flt; bkpt_armed = arm; bkpt_addr = baddr; req_ready = 1'b0;
    #1;
    chk(xl_vaddr == ea, {"R3 vaddr ", tag}, xl_vaddr, ea);
    @(negedge clk);
    in_valid = 1'b0; xl_fault = 1'b0;
    chk(dbg_exc == exc, {"R7/R8 exc ", tag}, dbg_exc, exc);
    if (exc) chk(dbg_exc_addr == ea, {"R7 exc addr ", tag}, dbg_exc_addr, ea);
    chk(req_valid == (nexp != 0), {"R10 first req ", tag}, req_valid, nexp != 0);
    n = 0; seen = 0; held = '0;
    for (int c = 0; c < 8; c++) begin
      req_ready = (c >= delay);
      #1;
      if (c == 1) chk(dbg_exc == 1'b0, {"R7 pulse ", tag}, dbg_exc, 0);
      if (req_valid && !req_ready) begin
        if (seen) chk(req_addr == held, {"R9 hold ", tag}, req_addr, held);
        chk(in_ready == 1'b0, {"R9 stall ", tag}, in_ready, 0);
        held = req_addr; seen = 1;
      end
      if (req_valid && req_ready && n < 4) begin
        got[n] = req_addr; got_w[n] = req_write; n++;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
    chk(n == nexp, {"R4/R6/R8 count ", tag}, n, nexp);
    if (n == 2 && nexp == 2) begin
      chk(got[0] == blk, {"R4 first ", tag}, got[0], blk);
      chk(got[1] == blk + 32, {"R4 second ", tag}, got[1], blk + 32);
      chk(got_w[0] == insn[12] && got_w[1] == insn[12], {"R1/R2 write ", tag}, got_w[0], insn[12]);
    end
  endtask

  task automatic wide(input logic [31:0] insn, input logic [31:0] base);
    logic [31:0] ea;
    ea = ea_of(insn, base);
    @(negedge clk);
    w_in_valid = 1'b1; in_insn = insn; in_base = base; xl_fault = 1'b0; bkpt_armed = 1'b0;
    @(negedge clk);
    w_in_valid = 1'b0;
    chk(w_req_valid == 1'b1, "R5 wide valid", w_req_valid, 1);
    chk(w_req_addr == {ea[31:8], 8'd0}, "R5 wide addr", w_req_addr, {ea[31:8], 8'd0});
    chk(w_req_write == insn[12], "R1/R2 wide write", w_req_write, insn[12]);
    @(negedge clk);
    chk(w_req_valid == 1'b0, "R5 single request", w_req_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] imms [0:3];
    logic [31:0] bases [0:3];
    logic [4:0]  rds [0:2];
    imms[0] = 12'h000; imms[1] = 12'h7ff; imms[2] = 12'h800; imms[3] = 12'hfc1;
    bases[0] = 32'h0000_1000; bases[1] = 32'h0000_203f; bases[2] = 32'h8000_0040; bases[3] = 32'hffff_fff0;
    rds[0] = 5'd0; rds[1] = 5'd1; rds[2] = 5'd31;
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R10 reset req", req_valid, 0);
    chk(dbg_exc == 1'b0, "R7 reset exc", dbg_exc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);

    for (int f3 = 0; f3 < 8; f3++)
      for (int r = 0; r < 3; r++)
        for (int op = 0; op < 2; op++)
          for (int k = 0; k < 4; k++)
            run(mk(imms[k], 3'(f3), rds[r], op == 0 ? 7'b0010011 : 7'b0110011),
                bases[k], 1'b0, 1'b0, '0, k, "sweep");

    for (int k = 0; k < 4; k++) begin
      run(mk(imms[k], 3'b110, 5'd0, 7'b0010011), bases[k], 1'b1, 1'b0, '0, 0, "R6 fault read");
      run(mk(imms[k], 3'b111, 5'd0, 7'b0010011), bases[k], 1'b1, 1'b0, '0, 0, "R6 fault write");
      run(mk(imms[k], 3'b110, 5'd0, 7'b0010011), bases[k], 1'b0, 1'b1,
          ea_of(mk(imms[k], 3'b110, 5'd0, 7'b0010011), bases[k]) ^ 32'h3f, 0, "R7 hit");
      run(mk(imms[k], 3'b111, 5'd0, 7'b0010011), bases[k], 1'b1, 1'b1,
          ea_of(mk(imms[k], 3'b111, 5'd0, 7'b0010011), bases[k]), 0, "R7 hit over fault");
      run(mk(imms[k], 3'b110, 5'd0, 7'b0010011), bases[k], 1'b0, 1'b1,
          ea_of(mk(imms[k], 3'b110, 5'd0, 7'b0010011), bases[k]) + 32'h40, 1, "R7 other block");
      run(mk(imms[k], 3'b111, 5'd0, 7'b0010011), bases[k], 1'b0, 1'b0,
          ea_of(mk(imms[k], 3'b111, 5'd0, 7'b0010011), bases[k]), 3, "R7 disarmed");
      run(mk(imms[k], 3'b110, 5'd4, 7'b0010011), bases[k], 1'b0, 1'b1,
          ea_of(mk(imms[k], 3'b110, 5'd4, 7'b0010011), bases[k]), 0, "R8 rd nonzero bkpt");
    end

    for (int k = 0; k < 4; k++) begin
      wide(mk(imms[k], 3'b110, 5'd0, 7'b0010011), bases[k]);
      wide(mk(imms[k], 3'b111, 5'd0, 7'b0010011), bases[k] + 32'h1c0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule